// File: doc/BRIEF.md
# Four-Point 2D Inverse Integer Transform

This block turns a 4x4 block of signed 16-bit transform coefficients into a 4x4 block of signed 16-bit residual samples. It is the last arithmetic step before prediction add-back in a video decoder. A column pass runs first. Its 4x4 result is kept in a local buffer and read back across, so the row pass sees the transposed orientation. Both passes share one even/odd butterfly with the fixed multipliers 64, 83 and 36. Each pass adds a rounding constant, shifts right arithmetically and saturates to 16 bits. The first pass always shifts by 7. The second pass shifts by 20 minus the sample bit depth, which is 8 or 10.

The coefficient block arrives as four row beats over a valid/ready handshake. The result leaves as four row beats over a second valid/ready handshake, row 0 first, so the samples come out in row-major order. The row pass is worked out as each output row is presented. The block holds one transform at a time and takes no new input until the last output row has been accepted.

A three-state machine sequences the work:
- LOAD: accepts rows and moves to COLS on the fourth accepted row.
- COLS: spends four cycles on the column pass, one column per cycle, then moves to DRAIN.
- DRAIN: presents output rows and moves back to LOAD when the fourth row is taken.

Top module: `itx4_core`

## Requirements
- R1: While reset is held, and in the first cycle after it, `in_ready` is 1 and `out_valid` is 0.
- R2: A block is loaded as exactly four accepted beats (`in_valid` and `in_ready` both 1), row 0 first. Within a row word, column c sits in bits [16c+15:16c] as two's complement.
- R3: From the fourth accepted row until the fourth output row is accepted, `in_ready` is 0 and `in_valid`/`in_row` have no effect on the result. After that, `in_ready` returns to 1.
- R4: The first pass works on each column (x0..x3 = rows 0..3). It forms e0=64(x0+x2), e1=64(x0-x2), o0=83x1+36x3 and o1=36x1-83x3. It then produces y0=e0+o0, y1=e1+o1, y2=e1-o1 and y3=e0-o0, each with 64 added and arithmetically shifted right by 7. All arithmetic is 32-bit signed.
- R5: The second pass applies the same butterfly to each row of the first-pass result. It shifts by 12 when `in_bd10` is 0 (8-bit samples) and by 10 when it is 1 (10-bit samples), after adding 1<<(shift-1).
- R6: The bit-depth select is taken with the first row beat of a block. Its value on later beats of the same block has no effect.
- R7: Output rows come out row 0 first, with the same lane packing as the input. While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_row` holds its value.
- R8: `out_valid` first rises exactly four clock cycles after the clock edge that accepts the fourth input row.
- R9: Each result of either pass is clamped to [-32768, 32767] before it is stored or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input row beat is present |
| in_ready | output | 1 | Block can accept an input row |
| in_row | input | 64 | Four coefficients of one row, column c in bits [16c+15:16c] |
| in_bd10 | input | 1 | Bit-depth select: 0 for 8-bit, 1 for 10-bit samples |
| out_valid | output | 1 | Output row beat is present |
| out_ready | input | 1 | Consumer takes the output row |
| out_row | output | 64 | Four residual samples of one row, same packing |

## Verification
A lone DC coefficient gives a flat block whose value is known by hand (1 for 8-bit, 2 for 10-bit). This separates the two second-pass shifts and the rounding. A block with one odd-position coefficient in row 0 and a negated one in row 1 is not symmetric, so it exposes a mix-up of rows and columns or of the transpose orientation. Blocks filled with the extreme values 32767 and -32768, or with those values alternating, drive the first pass into saturation in both directions. A block of mixed small and large values is compared with an independent model of the two-pass arithmetic. Further directed blocks offer junk input while the block is busy, change the bit-depth select partway through a load, and stall the output handshake.

// File: rtl/itx4_pkg.sv
package itx4_pkg;
    parameter int unsigned SMP_W     = 16;
    parameter int unsigned ACC_W     = 32;
    parameter int unsigned PTS       = 4;
    parameter int unsigned SH_W      = 5;
    localparam int unsigned CNT_W    = $clog2(PTS);
    localparam int unsigned ROW_W    = PTS * SMP_W;
    localparam int unsigned PASS1_SH = 7;
    localparam int unsigned DEPTH_SUM = 20;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_COLS  = 2'd1,
        ST_DRAIN = 2'd2
    } phase_t;
endpackage

// File: rtl/itx4_bfly.sv
module itx4_bfly
    import itx4_pkg::*;
#(
    parameter int unsigned LANE_W = SMP_W,
    parameter int unsigned WIDE_W = ACC_W
) (
    input  logic [4*LANE_W-1:0] vec_in,
    input  logic [SH_W-1:0]     shamt,
    output logic [4*LANE_W-1:0] vec_out
);
    localparam logic signed [WIDE_W-1:0] K64 = WIDE_W'(64);
    localparam logic signed [WIDE_W-1:0] K83 = WIDE_W'(83);
    localparam logic signed [WIDE_W-1:0] K36 = WIDE_W'(36);
    localparam logic signed [WIDE_W-1:0] SAT_HI = WIDE_W'((64'sd1 <<< (LANE_W - 1)) - 1);
    localparam logic signed [WIDE_W-1:0] SAT_LO = -SAT_HI - WIDE_W'(1);

    logic signed [WIDE_W-1:0] xs [4];
    logic signed [WIDE_W-1:0] sums [4];
    logic signed [WIDE_W-1:0] even0, even1, odd0, odd1, rnd;

    for (genvar i = 0; i < 4; i++) begin : g_ext
        assign xs[i] = WIDE_W'(signed'(vec_in[i*LANE_W +: LANE_W]));
    end

    always_comb begin
        even0 = K64 * (xs[0] + xs[2]);
        even1 = K64 * (xs[0] - xs[2]);
        odd0  = K83 * xs[1] + K36 * xs[3];
        odd1  = K36 * xs[1] - K83 * xs[3];
        sums[0] = even0 + odd0;
        sums[1] = even1 + odd1;
        sums[2] = even1 - odd1;
        sums[3] = even0 - odd0;
        rnd = (WIDE_W'(1) << shamt) >>> 1;
    end

    for (genvar i = 0; i < 4; i++) begin : g_lane
        logic signed [WIDE_W-1:0] scaled;
        always_comb begin
            scaled = (sums[i] + rnd) >>> shamt;
            if (scaled > SAT_HI)
                vec_out[i*LANE_W +: LANE_W] = SAT_HI[LANE_W-1:0];
            else if (scaled < SAT_LO)
                vec_out[i*LANE_W +: LANE_W] = SAT_LO[LANE_W-1:0];
            else
                vec_out[i*LANE_W +: LANE_W] = scaled[LANE_W-1:0];
        end
    end
endmodule

// File: rtl/itx4_ctrl.sv
module itx4_ctrl
    import itx4_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             load_en,
    output logic             col_en,
    output logic [CNT_W-1:0] cnt,
    output phase_t           phase
);
    phase_t           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             last;
    logic             step;

    assign last = (cnt_q == CNT_W'(PTS - 1));

    always_comb begin
        state_d = state_q;
        step    = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                step = in_valid;
                if (in_valid && last) state_d = ST_COLS;
            end
            ST_COLS: begin
                step = 1'b1;
                if (last) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                step = out_ready;
                if (out_ready && last) state_d = ST_LOAD;
            end
            default: state_d = ST_LOAD;
        endcase
        cnt_d = step ? cnt_q + CNT_W'(1) : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load_en   = 1'b0;
        col_en    = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                in_ready = 1'b1;
                load_en  = in_valid;
            end
            ST_COLS:  col_en    = 1'b1;
            ST_DRAIN: out_valid = 1'b1;
            default: ;
        endcase
        cnt   = cnt_q;
        phase = state_q;
    end
endmodule

// File: rtl/itx4_core.sv
module itx4_core
    import itx4_pkg::*;
#(
    parameter int unsigned LO_DEPTH = 8,
    parameter int unsigned HI_DEPTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [ROW_W-1:0] in_row,
    input  logic             in_bd10,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [ROW_W-1:0] out_row
);
    localparam logic [SH_W-1:0] SH_LO = SH_W'(DEPTH_SUM - LO_DEPTH);
    localparam logic [SH_W-1:0] SH_HI = SH_W'(DEPTH_SUM - HI_DEPTH);

    logic             load_en, col_en;
    logic [CNT_W-1:0] cnt;
    phase_t           phase;
    logic             bd_q;
    logic [SMP_W-1:0] buf_q [PTS][PTS];
    logic [ROW_W-1:0] col_vec, row_vec, bfly_in, bfly_out;
    logic [SH_W-1:0]  shamt;

    itx4_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load_en   (load_en),
        .col_en    (col_en),
        .cnt       (cnt),
        .phase     (phase)
    );

    always_comb begin
        for (int i = 0; i < PTS; i++) begin
            col_vec[i*SMP_W +: SMP_W] = buf_q[i][cnt];
            row_vec[i*SMP_W +: SMP_W] = buf_q[cnt][i];
        end
        if (phase == ST_COLS) begin
            bfly_in = col_vec;
            shamt   = SH_W'(PASS1_SH);
        end else begin
            bfly_in = row_vec;
            shamt   = bd_q ? SH_HI : SH_LO;
        end
    end

    itx4_bfly u_bfly (
        .vec_in  (bfly_in),
        .shamt   (shamt),
        .vec_out (bfly_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            bd_q <= 1'b0;
        else if (load_en && cnt == '0)
            bd_q <= in_bd10;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < PTS; i++) begin
            if (load_en)
                buf_q[cnt][i] <= in_row[i*SMP_W +: SMP_W];
            else if (col_en)
                buf_q[i][cnt] <= bfly_out[i*SMP_W +: SMP_W];
        end
    end

    assign out_row = bfly_out;
endmodule

// File: rtl/itx4_chk.sv
module itx4_chk
    import itx4_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [ROW_W-1:0] out_row
);
    logic [CNT_W:0]   acc_n;
    logic [CNT_W-1:0] out_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_n <= '0;
            out_n <= '0;
        end else begin
            if (in_valid && in_ready) acc_n <= acc_n + 1'b1;
            if (out_valid && out_ready) begin
                out_n <= out_n + 1'b1;
                if (out_n == CNT_W'(PTS - 1)) acc_n <= '0;
            end
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (in_ready && !out_valid));

    a_r2_full_block: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (acc_n == (CNT_W+1)'(PTS)));

    a_r3_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_n == (CNT_W+1)'(PTS)) |-> !in_ready);

    a_r3_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row)));

    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> ($past(in_ready, 5) && !$past(in_ready, 4)));
endmodule

bind itx4_core itx4_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_row   (out_row)
);

// File: tb/itx4_core_tb.sv
`timescale 1ns/1ps
module itx4_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_row = '0;
    logic        in_bd10 = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_row;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [255:0] got;

    always #2.5 clk = ~clk;

    itx4_core u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_row(in_row), .in_bd10(in_bd10), .out_valid(out_valid),
        .out_ready(out_ready), .out_row(out_row)
    );

    // {bit-depth select, block}; element (r,c) in bits [(4r+c)*16 +: 16]
    localparam logic [256:0] VECS [7] = '{
        {1'b0, 256'h40},
        {1'b1, 256'h40},
        {1'b0, {16{16'h7fff}}},
        {1'b1, {16{16'h8000}}},
        {1'b0, {8{16'h8000, 16'h7fff}}},
        {1'b1, 64'h0010_fff0_0100_ff00, 64'h0003_0005_fffb_0007,
               64'h1234_edcc_0000_0001, 64'h0000_0020_ffe0_0400},
        {1'b0, 128'h0, 64'h0000_0000_0000_ff9c, 64'h0000_0000_0064_0000}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_1d(input logic [63:0] v, input int sh);
        longint x [4];
        longint y [4];
        logic [63:0] r;
        for (int i = 0; i < 4; i++) x[i] = longint'($signed(v[i*16 +: 16]));
        y[0] = 64*(x[0]+x[2]) + (83*x[1] + 36*x[3]);
        y[1] = 64*(x[0]-x[2]) + (36*x[1] - 83*x[3]);
        y[2] = 64*(x[0]-x[2]) - (36*x[1] - 83*x[3]);
        y[3] = 64*(x[0]+x[2]) - (83*x[1] + 36*x[3]);
        for (int i = 0; i < 4; i++) begin
            longint t;
            t = (y[i] + (64'sd1 <<< (sh - 1))) >>> sh;
            if (t > 32767) t = 32767;
            if (t < -32768) t = -32768;
            r[i*16 +: 16] = t[15:0];
        end
        return r;
    endfunction

    function automatic logic [255:0] ref_2d(input logic [255:0] blk, input logic bd);
        logic [255:0] m = blk;
        for (int c = 0; c < 4; c++) begin
            logic [63:0] col, res;
            for (int r = 0; r < 4; r++) col[r*16 +: 16] = m[(r*4+c)*16 +: 16];
            res = ref_1d(col, 7);
            for (int r = 0; r < 4; r++) m[(r*4+c)*16 +: 16] = res[r*16 +: 16];
        end
        for (int r = 0; r < 4; r++) m[r*64 +: 64] = ref_1d(m[r*64 +: 64], bd ? 10 : 12);
        return m;
    endfunction

    task automatic run_block(input logic [255:0] blk, input logic bd_a, input logic bd_b,
                             input bit junk, input int stall_row, input string tag);
        logic [255:0] exp;
        int lat;
        exp = ref_2d(blk, bd_a);
        for (int r = 0; r < 4; r++) begin
            @(negedge clk);
            chk(in_ready === 1'b1, "R2 ready during load", {63'd0, in_ready}, 64'd1);
            in_valid = 1'b1;
            in_row   = blk[r*64 +: 64];
            in_bd10  = (r == 0) ? bd_a : bd_b;
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = junk;
        in_row   = 64'h7fff_8000_7fff_8000;
        in_bd10  = ~bd_a;
        lat = 1;
        while (!out_valid && lat < 20) begin
            if (junk) chk(in_ready === 1'b0, "R3 busy in compute", {63'd0, in_ready}, 64'd0);
            @(negedge clk);
            lat++;
        end
        chk(lat == 5, "R8 latency", 64'(lat), 64'd5);
        for (int r = 0; r < 4; r++) begin
            if (r == stall_row) begin
                logic [63:0] held;
                held = out_row;
                out_ready = 1'b0;
                repeat (3) begin
                    @(negedge clk);
                    chk(out_valid === 1'b1 && out_row === held, "R7 stall hold", out_row, held);
                end
                out_ready = 1'b1;
            end
            chk(out_valid === 1'b1, {"R7 valid ", tag}, {63'd0, out_valid}, 64'd1);
            chk(out_row === exp[r*64 +: 64], {"R4 R5 R9 row ", tag}, out_row, exp[r*64 +: 64]);
            if (junk) chk(in_ready === 1'b0, "R3 busy in drain", {63'd0, in_ready}, 64'd0);
            got[r*64 +: 64] = out_row;
            @(posedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(in_ready === 1'b1 && out_valid === 1'b0, "R3 ready after drain",
            {62'd0, in_ready, out_valid}, 64'd2);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(in_ready === 1'b1 && out_valid === 1'b0, "R1 during reset", {62'd0, in_ready, out_valid}, 64'd2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready === 1'b1 && out_valid === 1'b0, "R1 after reset", {62'd0, in_ready, out_valid}, 64'd2);

        // table walk: R2 R4 R5 R7 R8 R9 against model
        for (int k = 0; k < 7; k++)
            run_block(VECS[k][255:0], VECS[k][256], VECS[k][256], 1'b0, -1, $sformatf("vec%0d", k));

        // R4 R5 hand values: DC 64 gives flat 1 (8-bit) and 2 (10-bit)
        run_block(256'h40, 1'b0, 1'b0, 1'b0, -1, "dc8");
        for (int r = 0; r < 4; r++)
            chk(got[r*64 +: 64] === 64'h0001_0001_0001_0001, "R5 dc 8-bit", got[r*64 +: 64], 64'h0001_0001_0001_0001);
        run_block(256'h40, 1'b1, 1'b1, 1'b0, -1, "dc10");
        chk(got[63:0] === 64'h0002_0002_0002_0002, "R5 dc 10-bit", got[63:0], 64'h0002_0002_0002_0002);

        // R9 first-pass saturation, row 0 by hand: 1976, -376, 376, 72
        run_block({16{16'h7fff}}, 1'b0, 1'b0, 1'b0, -1, "sat");
        chk(got[63:0] === 64'h0048_0178_fe88_07b8, "R9 saturated row0", got[63:0], 64'h0048_0178_fe88_07b8);

        // R6 select taken on first beat only
        run_block(256'h40, 1'b0, 1'b1, 1'b0, -1, "bd-late");
        chk(got[63:0] === 64'h0001_0001_0001_0001, "R6 late select ignored", got[63:0], 64'h0001_0001_0001_0001);
        run_block(256'h40, 1'b1, 1'b0, 1'b0, -1, "bd-first");
        chk(got[255:192] === 64'h0002_0002_0002_0002, "R6 first select used", got[255:192], 64'h0002_0002_0002_0002);

        // R3 junk while busy, R7 stall on row 1
        run_block(VECS[5][255:0], 1'b1, 1'b1, 1'b1, 1, "junk-stall");
        // R2 asymmetric block again after junk: confirms nothing leaked in
        run_block(VECS[6][255:0], 1'b0, 1'b0, 1'b0, 3, "after-junk");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule